// File: doc/BRIEF.md
# Fat-Tree Up/Down Route Generator

This block turns a pair of node numbers in a quaternary fat tree of dimension `DIM` into a minimal route, written as a list of per-hop routing tags. Each node number has `DIM` base-4 digits, two bits per digit, with digit 0 in the lowest bits. The block finds the most significant digit in which the source and destination differ. That digit fixes the level of the nearest common ancestor switch. The route climbs to that level and then descends to the destination.

Climbing hops are written as a group tag meaning "any up-link", so each switch on the way up can choose its least loaded link. Descending hops name one child port each, taken from the destination's digits, highest level first. A request is accepted on a valid/ready handshake. The hop count is shown from the next cycle, and the tags are then streamed one per accepted beat on a second valid/ready handshake. A request whose source equals its destination produces no tags and raises a self-route flag.

Top module: `fat_route_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `tag_valid` is 0, `hop_count` is 0 and `self_route` is 0.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `hop_count` equals twice (1 + index of the most significant differing base-4 digit of `src_id` and `dst_id`). Nodes sharing a first-level switch get 2 hops, and with `DIM`=3 a top-digit difference gives 6 hops.
- R3: The first `hop_count/2` tags of a route are each the up-group code 3'b100 (bit 2 set, port bits 0).
- R4: The remaining tags are down tags of the form {1'b0, digit}, where digit is the destination's base-4 digit. They are emitted from digit index `hop_count/2-1` down to digit 0, and no up tag follows a down tag.
- R5: `tag_last` is 1 on the final tag of a route only, and `tag_valid` falls in the cycle after that tag is accepted.
- R6: A request with `src_id` equal to `dst_id` sets `self_route` to 1 and `hop_count` to 0 in the next cycle, emits no tag, and leaves `req_ready` high.
- R7: While `tag_valid` is 1 and `tag_ready` is 0, `tag_data`, `tag_last` and `tag_valid` hold their values.
- R8: `req_ready` is 0 while a route is being streamed, and a `req_valid` raised during that time does not alter the tags of the route in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Route request present |
| req_ready | output | 1 | Block is idle and can take a request |
| src_id | input | 2*DIM | Source node number, base-4 digits |
| dst_id | input | 2*DIM | Destination node number, base-4 digits |
| hop_count | output | $clog2(DIM+1)+1 | Hop count of the last accepted request |
| self_route | output | 1 | Last accepted request had equal source and destination |
| tag_valid | output | 1 | A routing tag is presented |
| tag_ready | input | 1 | Consumer takes the tag |
| tag_data | output | 3 | Tag: bit 2 up-group flag, bits 1:0 child port |
| tag_last | output | 1 | Final tag of the route |

## Verification
Pairs of nodes are chosen so that their first difference lies in each digit in turn. A neighbour pair on one first-level switch tells apart a level taken from the lowest digit from one taken from any other. A middle-digit pair whose lower digits match checks that only the highest difference counts. Source 0 to destination 63 and the reverse reach the top level and the full length. An equal pair exercises the empty route. Streams are drained both with ready held high and with stall cycles, and a request is raised mid-stream, so that hold behaviour and blocking of new requests are told apart from plain sequencing.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int TAG_W = 3;

  typedef struct packed {
    logic       up;
    logic [1:0] port;
  } fr_tag_t;

  localparam fr_tag_t UP_GROUP = '{up: 1'b1, port: 2'b00};
endpackage

// File: rtl/fr_level_calc.sv
// Finds the ancestor level: one plus the most significant differing digit.
module fr_level_calc #(
  parameter int DIM   = 3,
  parameter int ID_W  = 2 * DIM,
  parameter int LVL_W = $clog2(DIM + 1)
) (
  input  logic [ID_W-1:0]  a_id,
  input  logic [ID_W-1:0]  b_id,
  output logic [LVL_W-1:0] level
);
  logic [DIM-1:0] diff;

  generate
    for (genvar g = 0; g < DIM; g++) begin : g_dig
      assign diff[g] = (a_id[2*g +: 2] != b_id[2*g +: 2]);
    end
  endgenerate

  always_comb begin
    level = '0;
    for (int d = 0; d < DIM; d++) begin
      if (diff[d]) level = LVL_W'(d + 1);
    end
  end
endmodule

// File: rtl/fr_tag_sel.sv
// Picks the tag for hop position idx of a route climbing to 'level'.
module fr_tag_sel
  import fr_pkg::*;
#(
  parameter int DIM   = 3,
  parameter int ID_W  = 2 * DIM,
  parameter int LVL_W = $clog2(DIM + 1),
  parameter int HOP_W = LVL_W + 1
) (
  input  logic [HOP_W-1:0] idx,
  input  logic [LVL_W-1:0] level,
  input  logic [ID_W-1:0]  dst,
  output fr_tag_t          tag
);
  logic [HOP_W-1:0] lvl_ext;
  logic [HOP_W-1:0] dig_pos;
  logic [1:0]       digit;

  assign lvl_ext = {1'b0, level};
  assign dig_pos = {level, 1'b0} - HOP_W'(1) - idx;

  always_comb begin
    digit = 2'b00;
    for (int d = 0; d < DIM; d++) begin
      if (dig_pos == HOP_W'(d)) digit = dst[2*d +: 2];
    end
  end

  always_comb begin
    if (idx < lvl_ext) begin
      tag = UP_GROUP;
    end else begin
      tag.up   = 1'b0;
      tag.port = digit;
    end
  end
endmodule

// File: rtl/fr_stream_ctl.sv
// Captures an accepted request and steps through its hops.
module fr_stream_ctl #(
  parameter int DIM   = 3,
  parameter int ID_W  = 2 * DIM,
  parameter int LVL_W = $clog2(DIM + 1),
  parameter int HOP_W = LVL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] new_level,
  input  logic [ID_W-1:0]  new_dst,
  input  logic             tag_ready,
  output logic             busy,
  output logic [HOP_W-1:0] idx,
  output logic [LVL_W-1:0] level,
  output logic [ID_W-1:0]  dst,
  output logic [HOP_W-1:0] hops,
  output logic             self_flag,
  output logic             last
);
  logic             busy_q, busy_d;
  logic [HOP_W-1:0] idx_q, idx_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [ID_W-1:0]  dst_q, dst_d;
  logic             self_q, self_d;
  logic             accept, step, en;

  assign accept = req_valid && !busy_q;
  assign last   = busy_q && (idx_q == {lvl_q, 1'b0} - HOP_W'(1));
  assign step   = busy_q && tag_ready;
  assign en     = accept || step;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    lvl_d  = lvl_q;
    dst_d  = dst_q;
    self_d = self_q;
    if (accept) begin
      busy_d = (new_level != '0);
      idx_d  = '0;
      lvl_d  = new_level;
      dst_d  = new_dst;
      self_d = (new_level == '0);
    end else if (step) begin
      if (last) busy_d = 1'b0;
      else      idx_d  = idx_q + HOP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      lvl_q  <= '0;
      dst_q  <= '0;
      self_q <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      lvl_q  <= lvl_d;
      dst_q  <= dst_d;
      self_q <= self_d;
    end
  end

  assign busy      = busy_q;
  assign idx       = idx_q;
  assign level     = lvl_q;
  assign dst       = dst_q;
  assign hops      = {lvl_q, 1'b0};
  assign self_flag = self_q;
endmodule

// File: rtl/fat_route_gen.sv
module fat_route_gen
  import fr_pkg::*;
#(
  parameter int DIM = 3,
  localparam int ID_W  = 2 * DIM,
  localparam int LVL_W = $clog2(DIM + 1),
  localparam int HOP_W = LVL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ID_W-1:0]  src_id,
  input  logic [ID_W-1:0]  dst_id,
  output logic [HOP_W-1:0] hop_count,
  output logic             self_route,
  output logic             tag_valid,
  input  logic             tag_ready,
  output logic [TAG_W-1:0] tag_data,
  output logic             tag_last
);
  logic [LVL_W-1:0] new_level, cur_level;
  logic [ID_W-1:0]  cur_dst;
  logic [HOP_W-1:0] cur_idx;
  logic             busy, last;
  fr_tag_t          tag;

  fr_level_calc #(.DIM(DIM)) u_lvl (
    .a_id  (src_id),
    .b_id  (dst_id),
    .level (new_level)
  );

  fr_stream_ctl #(.DIM(DIM)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .new_level (new_level),
    .new_dst   (dst_id),
    .tag_ready (tag_ready),
    .busy      (busy),
    .idx       (cur_idx),
    .level     (cur_level),
    .dst       (cur_dst),
    .hops      (hop_count),
    .self_flag (self_route),
    .last      (last)
  );

  fr_tag_sel #(.DIM(DIM)) u_sel (
    .idx   (cur_idx),
    .level (cur_level),
    .dst   (cur_dst),
    .tag   (tag)
  );

  assign req_ready = !busy;
  assign tag_valid = busy;
  assign tag_data  = tag;
  assign tag_last  = last;
endmodule

// File: rtl/fr_route_chk.sv
module fr_route_chk #(
  parameter int DIM = 3,
  localparam int ID_W  = 2 * DIM,
  localparam int LVL_W = $clog2(DIM + 1),
  localparam int HOP_W = LVL_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [ID_W-1:0]  src_id,
  input logic [ID_W-1:0]  dst_id,
  input logic [HOP_W-1:0] hop_count,
  input logic             self_route,
  input logic             tag_valid,
  input logic             tag_ready,
  input logic [2:0]       tag_data,
  input logic             tag_last
);
  // R2
  route_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && src_id != dst_id) |=>
      (tag_valid && hop_count != '0 && !hop_count[0] && !self_route));

  // R4
  down_then_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_ready && !tag_data[2] && !tag_last) |=> (tag_valid && !tag_data[2]));

  // R5
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_ready && tag_last) |=> !tag_valid);

  // R6
  self_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && src_id == dst_id) |=>
      (self_route && hop_count == '0 && !tag_valid && req_ready));

  // R7
  hold_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_ready) |=> (tag_valid && $stable(tag_data) && $stable(tag_last)));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> !req_ready);
endmodule

bind fat_route_gen fr_route_chk #(.DIM(DIM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .src_id     (src_id),
  .dst_id     (dst_id),
  .hop_count  (hop_count),
  .self_route (self_route),
  .tag_valid  (tag_valid),
  .tag_ready  (tag_ready),
  .tag_data   (tag_data),
  .tag_last   (tag_last)
);

// File: tb/sim_fat_route_gen.sv
`timescale 1ns/1ps
module sim_fat_route_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DIM = 3;
  localparam int ID_W = 2 * DIM;
  localparam int HOP_W = $clog2(DIM + 1) + 1;

  logic             clk, rst_n;
  logic             req_valid, req_ready;
  logic [ID_W-1:0]  src_id, dst_id;
  logic [HOP_W-1:0] hop_count;
  logic             self_route, tag_valid, tag_ready, tag_last;
  logic [2:0]       tag_data;

  int errors = 0;
  int checks = 0;

  fat_route_gen #(.DIM(DIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .src_id(src_id), .dst_id(dst_id), .hop_count(hop_count),
    .self_route(self_route), .tag_valid(tag_valid), .tag_ready(tag_ready),
    .tag_data(tag_data), .tag_last(tag_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Ancestor level from the requirement: scan digits from the top.
  function automatic int exp_level(input int s, input int d);
    for (int k = DIM - 1; k >= 0; k--)
      if (((s >> (2 * k)) & 3) != ((d >> (2 * k)) & 3)) return k + 1;
    return 0;
  endfunction

  function automatic int exp_tag(input int d, input int lvl, input int i);
    if (i < lvl) return 4;
    return (d >> (2 * (2 * lvl - 1 - i))) & 3;
  endfunction

  task automatic issue(input int s, input int d, input bit poke_busy, input bit stall);
    int lvl, hops, n;
    lvl  = exp_level(s, d);
    hops = 2 * lvl;
    @(negedge clk);
    req_valid = 1'b1; src_id = ID_W'(s); dst_id = ID_W'(d);
    @(negedge clk);
    req_valid = 1'b0;
    check(hop_count == HOP_W'(hops), "R2 hop count", hop_count, hops);
    check(self_route == (hops == 0), "R6 self flag", self_route, hops == 0);
    if (hops == 0) begin
      check(!tag_valid && req_ready, "R6 no tags, ready high", tag_valid, 0);
      return;
    end
    if (poke_busy) begin
      req_valid = 1'b1; src_id = ID_W'(d); dst_id = ID_W'(s ^ 1);
      check(!req_ready, "R8 ready low while streaming", req_ready, 0);
    end
    n = 0;
    for (int i = 0; i < hops; i++) begin
      if (stall && (i % 2 == 0)) begin
        logic [2:0] held;
        logic       held_last;
        tag_ready = 1'b0;
        held = tag_data; held_last = tag_last;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag_valid && tag_data == held && tag_last == held_last,
              "R7 tag held under stall", tag_data, held);
      end
      tag_ready = 1'b1;
      check(tag_valid, "R5 tag valid during route", tag_valid, 1);
      if (i < lvl)
        check(tag_data == 3'(exp_tag(d, lvl, i)), "R3 up-group tag", tag_data, exp_tag(d, lvl, i));
      else
        check(tag_data == 3'(exp_tag(d, lvl, i)), "R4 down tag", tag_data, exp_tag(d, lvl, i));
      check(tag_last == (i == hops - 1), "R5 last flag", tag_last, i == hops - 1);
      n++;
      @(negedge clk);
      req_valid = 1'b0;
    end
    tag_ready = 1'b0;
    check(!tag_valid && req_ready, "R5 stream ended", tag_valid, 0);
    check(n == hops, "R8 tag count", n, hops);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(tag_valid == 1'b0, "R1 tag_valid", tag_valid, 0);
    check(hop_count == '0, "R1 hop_count", hop_count, 0);
    check(self_route == 1'b0, "R1 self_route", self_route, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; tag_ready = 1'b0;
    src_id = '0; dst_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    issue(0, 1, 1'b0, 1'b0);    // R2 neighbours on one first-level switch
    issue(5, 9, 1'b0, 1'b0);    // R2 middle digit decides
    issue(0, 63, 1'b0, 1'b0);   // R2 top level, 6 hops
    issue(63, 0, 1'b0, 1'b1);   // R7 stalls on full route
    issue(21, 21, 1'b0, 1'b0);  // R6 self route
    issue(16, 39, 1'b1, 1'b0);  // R8 request raised mid-stream
    issue(44, 46, 1'b0, 1'b1);  // R4 lowest-level down port under stall
    issue(7, 7, 1'b0, 1'b0);    // R6 again after a route
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule